// File: doc/BRIEF.md
# Write-Once Snooping Coherence Controller

This block keeps one processor's small direct-mapped cache coherent with its peers on a single shared bus. Every line carries one of four states: Invalid, Valid (clean, possibly also held elsewhere), Reserved (clean, held only here) and Dirty (modified, held only here). The protocol has no invalidate or read-for-ownership command. The first processor write to a Valid line goes through to memory as an ordinary bus write, and every other cache that sees that write drops its copy. Later writes to the same line stay local.

The processor side uses a valid/ready handshake, with one data word per line. The bus side raises a request and holds the transaction type, address and data until an external arbiter grants it. The transaction completes in the grant cycle. The snoop side watches the transactions granted to other caches. It updates local line states, and when another cache reads a line held Dirty here, it raises an intervention flag and drives the line's data so that memory and the reader see the current value. A snoop on the index of a pending processor request takes precedence, and the request is decided again against the new state before any bus transaction is issued for it.

Top module: `wo_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address goes to the bus. `cpu_ready`, `bus_req` and `snp_flush` are low while nothing is requested.
- R2: A processor read miss issues a bus read (`bus_op` = 0) of the requested address. It returns `bus_rdata` on `cpu_rdata` with `cpu_ready` in the grant cycle and leaves the line Valid. A later read of the same address completes in the cycle it is presented and causes no bus traffic.
- R3: A processor write to a Valid line issues a bus write-through (`bus_op` = 1) carrying the address and write data. `cpu_ready` rises in the grant cycle, and the line becomes Reserved.
- R4: A processor write to a Reserved or Dirty line completes in the cycle it is presented, with no bus transaction, and leaves the line Dirty.
- R5: A processor write miss first performs a bus read of the line and then a write-through of the data. The line is left Reserved, not Dirty, so evicting it later needs no write-back.
- R6: A snooped write-through or write-back that matches a locally held line makes it Invalid, so the next local access to it misses.
- R7: A snooped bus read that matches a local Dirty line raises `snp_flush` in that cycle with the line's data on `snp_fdata`, and the line becomes Valid. A match on a Reserved line makes it Valid without a flush, so the next local write goes through to memory.
- R8: A miss whose victim line is Dirty first issues a write-back (`bus_op` = 2) of the victim's address and data, then serves the request. Replacing a Valid or Reserved victim causes no write-back.
- R9: When a snoop hits the index of a processor request that is being decided or is waiting for the bus, the snoop is applied first. The waiting request withdraws without a transaction and is decided again from the updated state.
- R10: `bus_req` stays high with `bus_op`, `bus_addr` and `bus_wdata` unchanged until `bus_gnt`. The transaction completes in the grant cycle. Each granted transaction appears once on the bus.
- R11: Whenever one cache holds a line Reserved or Dirty, the other cache holds it Invalid. A read by the other cache always goes to the bus and returns the most recently written value.
- Address split: the low log2(LINES) address bits select the line, and the remaining upper bits form the tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Request address |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Read data, valid with cpu_ready on a read |
| bus_req | output | 1 | Bus transaction pending |
| bus_gnt | input | 1 | Grant; the transaction completes this cycle |
| bus_op | output | 2 | 0 read, 1 write-through, 2 write-back, 3 idle |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Data for write-through and write-back |
| bus_rdata | input | DW | Read data in the grant cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_op | input | 2 | Type of the snooped transaction |
| snp_addr | input | AW | Address of the snooped transaction |
| snp_flush | output | 1 | Intervention: this cache supplies Dirty data |
| snp_fdata | output | DW | Data supplied with snp_flush |

## Verification
A hit completes in the cycle it is presented, so the bench expects `cpu_ready` at its first sample. Each bus transaction needs one grant cycle plus one decision cycle before the next one, so a request with n transactions and an idle bus finishes 2n-1 cycles after it is presented. The bench derives n from its own state model and checks that count. Bus transactions are compared in the cycle of their grant, including the intervention flag and the data that the peer or memory supplies. A snoop's effect on a line is checked through the next processor access to that line. All outputs are sampled 2 ns after the falling clock edge, and inputs change only on falling edges.

// File: rtl/wo_pkg.sv
`timescale 1ns/1ps
package wo_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_VAL = 2'd1,
      LS_RSV = 2'd2,
      LS_DRT = 2'd3
   } line_st_e;

   typedef enum logic [1:0] {
      BOP_READ  = 2'd0,
      BOP_WTHRU = 2'd1,
      BOP_WBACK = 2'd2,
      BOP_IDLE  = 2'd3
   } bus_op_e;

   typedef enum logic {
      PH_EVAL = 1'b0,
      PH_BUS  = 1'b1
   } ctrl_ph_e;
endpackage

// File: rtl/wo_line_store.sv
`timescale 1ns/1ps
module wo_line_store
   import wo_pkg::*;
#(
   parameter int LINES = 4,
   parameter int TW    = 6,
   parameter int DW    = 16,
   localparam int IW   = $clog2(LINES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [IW-1:0]  ra_idx,
   output line_st_e       ra_st,
   output logic [TW-1:0]  ra_tag,
   output logic [DW-1:0]  ra_data,
   input  logic [IW-1:0]  rb_idx,
   output line_st_e       rb_st,
   output logic [TW-1:0]  rb_tag,
   output logic [DW-1:0]  rb_data,
   input  logic           pw_en,
   input  logic [IW-1:0]  pw_idx,
   input  line_st_e       pw_st,
   input  logic [TW-1:0]  pw_tag,
   input  logic [DW-1:0]  pw_data,
   input  logic           sw_en,
   input  logic [IW-1:0]  sw_idx,
   input  line_st_e       sw_st
);
   line_st_e      st_q   [LINES];
   logic [TW-1:0] tag_q  [LINES];
   logic [DW-1:0] data_q [LINES];

   initial begin
      assert (LINES >= 2 && (1 << IW) == LINES)
         else $error("line count must be a power of two, at least 2");
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q[g]   <= LS_INV;
            tag_q[g]  <= '0;
            data_q[g] <= '0;
         end else if (pw_en && pw_idx == IW'(g)) begin
            st_q[g]   <= pw_st;
            tag_q[g]  <= pw_tag;
            data_q[g] <= pw_data;
         end else if (sw_en && sw_idx == IW'(g)) begin
            st_q[g]   <= sw_st;
         end
      end
   end

   assign ra_st   = st_q[ra_idx];
   assign ra_tag  = tag_q[ra_idx];
   assign ra_data = data_q[ra_idx];
   assign rb_st   = st_q[rb_idx];
   assign rb_tag  = tag_q[rb_idx];
   assign rb_data = data_q[rb_idx];

   // R9
   port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pw_en && sw_en && pw_idx == sw_idx));
endmodule

// File: rtl/wo_snoop_unit.sv
`timescale 1ns/1ps
module wo_snoop_unit
   import wo_pkg::*;
#(
   parameter int TW = 6,
   parameter int DW = 16
) (
   input  logic          snp_valid,
   input  logic [1:0]    snp_op,
   input  logic [TW-1:0] snp_tag,
   input  line_st_e      ln_st,
   input  logic [TW-1:0] ln_tag,
   input  logic [DW-1:0] ln_data,
   output logic          upd_en,
   output line_st_e      upd_st,
   output logic          flush,
   output logic [DW-1:0] fdata
);
   logic hit;

   assign hit   = snp_valid && (ln_st != LS_INV) && (ln_tag == snp_tag);
   assign fdata = ln_data;

   always_comb begin
      upd_en = 1'b0;
      upd_st = ln_st;
      flush  = 1'b0;
      if (hit) begin
         case (bus_op_e'(snp_op))
            BOP_READ: begin
               if (ln_st == LS_DRT) flush = 1'b1;
               if (ln_st == LS_DRT || ln_st == LS_RSV) begin
                  upd_en = 1'b1;
                  upd_st = LS_VAL;
               end
            end
            BOP_WTHRU, BOP_WBACK: begin
               upd_en = 1'b1;
               upd_st = LS_INV;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/wo_coh_ctrl.sv
`timescale 1ns/1ps
module wo_coh_ctrl
   import wo_pkg::*;
#(
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int LINES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_valid,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_ready,
   output logic [DW-1:0] cpu_rdata,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic [1:0]    bus_op,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   input  logic          snp_valid,
   input  logic [1:0]    snp_op,
   input  logic [AW-1:0] snp_addr,
   output logic          snp_flush,
   output logic [DW-1:0] snp_fdata
);
   localparam int IW = $clog2(LINES);
   localparam int TW = AW - IW;

   initial begin
      assert (AW > IW) else $error("address narrower than the index");
      assert (DW >= 1) else $error("data width must be positive");
   end

   logic [IW-1:0] c_idx, s_idx;
   logic [TW-1:0] c_tag, s_tag;
   assign c_idx = cpu_addr[IW-1:0];
   assign c_tag = cpu_addr[AW-1:IW];
   assign s_idx = snp_addr[IW-1:0];
   assign s_tag = snp_addr[AW-1:IW];

   line_st_e      a_st, b_st;
   logic [TW-1:0] a_tag, b_tag;
   logic [DW-1:0] a_data, b_data;
   logic          pw_en, sw_en;
   line_st_e      pw_st, sw_st;
   logic [TW-1:0] pw_tag;
   logic [DW-1:0] pw_data;

   wo_line_store #(.LINES(LINES), .TW(TW), .DW(DW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_idx  (c_idx),
      .ra_st   (a_st),
      .ra_tag  (a_tag),
      .ra_data (a_data),
      .rb_idx  (s_idx),
      .rb_st   (b_st),
      .rb_tag  (b_tag),
      .rb_data (b_data),
      .pw_en   (pw_en),
      .pw_idx  (c_idx),
      .pw_st   (pw_st),
      .pw_tag  (pw_tag),
      .pw_data (pw_data),
      .sw_en   (sw_en),
      .sw_idx  (s_idx),
      .sw_st   (sw_st)
   );

   wo_snoop_unit #(.TW(TW), .DW(DW)) u_snoop (
      .snp_valid (snp_valid),
      .snp_op    (snp_op),
      .snp_tag   (s_tag),
      .ln_st     (b_st),
      .ln_tag    (b_tag),
      .ln_data   (b_data),
      .upd_en    (sw_en),
      .upd_st    (sw_st),
      .flush     (snp_flush),
      .fdata     (snp_fdata)
   );

   ctrl_ph_e      phase_q, phase_d;
   bus_op_e       bop_q, bop_d;
   logic [AW-1:0] baddr_q, baddr_d;
   logic [DW-1:0] bdata_q, bdata_d;
   logic          c_hit, snp_clash, eval_go, rdy;

   assign c_hit     = (a_st != LS_INV) && (a_tag == c_tag);
   assign snp_clash = snp_valid && (s_idx == c_idx);
   assign eval_go   = (phase_q == PH_EVAL) && cpu_valid && !snp_clash;

   always_comb begin
      phase_d = phase_q;
      bop_d   = bop_q;
      baddr_d = baddr_q;
      bdata_d = bdata_q;
      pw_en   = 1'b0;
      pw_st   = LS_INV;
      pw_tag  = c_tag;
      pw_data = cpu_wdata;
      rdy     = 1'b0;
      if (phase_q == PH_EVAL) begin
         if (eval_go) begin
            if (c_hit) begin
               if (!cpu_we) begin
                  rdy = 1'b1;
               end else if (a_st == LS_VAL) begin
                  phase_d = PH_BUS;
                  bop_d   = BOP_WTHRU;
                  baddr_d = cpu_addr;
                  bdata_d = cpu_wdata;
               end else begin
                  pw_en = 1'b1;
                  pw_st = LS_DRT;
                  rdy   = 1'b1;
               end
            end else if (a_st == LS_DRT) begin
               phase_d = PH_BUS;
               bop_d   = BOP_WBACK;
               baddr_d = {a_tag, c_idx};
               bdata_d = a_data;
            end else begin
               phase_d = PH_BUS;
               bop_d   = BOP_READ;
               baddr_d = cpu_addr;
               bdata_d = '0;
            end
         end
      end else if (bus_gnt) begin
         phase_d = PH_EVAL;
         case (bop_q)
            BOP_READ: begin
               pw_en   = 1'b1;
               pw_st   = LS_VAL;
               pw_data = bus_rdata;
               rdy     = !cpu_we;
            end
            BOP_WTHRU: begin
               pw_en   = 1'b1;
               pw_st   = LS_RSV;
               pw_data = bdata_q;
               rdy     = 1'b1;
            end
            BOP_WBACK: begin
               pw_en   = 1'b1;
               pw_st   = LS_INV;
               pw_tag  = a_tag;
               pw_data = a_data;
            end
            default: ;
         endcase
      end else if (snp_clash) begin
         phase_d = PH_EVAL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_EVAL;
         bop_q   <= BOP_IDLE;
         baddr_q <= '0;
         bdata_q <= '0;
      end else begin
         phase_q <= phase_d;
         bop_q   <= bop_d;
         baddr_q <= baddr_d;
         bdata_q <= bdata_d;
      end
   end

   assign cpu_ready = rdy;
   assign cpu_rdata = (phase_q == PH_BUS) ? bus_rdata : a_data;
   assign bus_req   = (phase_q == PH_BUS);
   assign bus_op    = bus_req ? bop_q : BOP_IDLE;
   assign bus_addr  = baddr_q;
   assign bus_wdata = bdata_q;

   // R1
   ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_valid);

   // R3
   wthru_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_go && cpu_we && c_hit && a_st == LS_VAL)
      |=> (bus_req && bus_op == BOP_WTHRU && bus_wdata == $past(cpu_wdata)));

   // R4
   local_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_go && cpu_we && c_hit && (a_st == LS_RSV || a_st == LS_DRT))
      |=> !bus_req);

   // R7
   flush_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> (snp_valid && snp_op == BOP_READ));

   // R8
   evict_wback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_go && !c_hit && a_st == LS_DRT)
      |=> (bus_req && bus_op == BOP_WBACK && bus_wdata == $past(a_data)));

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt && !snp_valid)
      |=> (bus_req && $stable(bus_op) && $stable(bus_addr) && $stable(bus_wdata)));

   // R10
   gnt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !bus_gnt);
endmodule

// File: tb/wo_coh_ctrl_test.sv
`timescale 1ns/1ps
module wo_coh_ctrl_test;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int LINES = 4;

   typedef struct {
      int            cid;
      logic [1:0]    op;
      logic [AW-1:0] adr;
      logic [DW-1:0] dat;
      logic          fl;
      string         rq;
   } bitem_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          cv [2];
   logic          cw [2];
   logic [AW-1:0] ca [2];
   logic [DW-1:0] cd [2];
   logic          cr0, cr1;
   logic [DW-1:0] cq0, cq1;

   logic          b0_req, b1_req, g0, g1;
   logic [1:0]    b0_op, b1_op;
   logic [AW-1:0] b0_adr, b1_adr, gadr;
   logic [DW-1:0] b0_wd, b1_wd, brd;
   logic          s0_fl, s1_fl;
   logic [DW-1:0] s0_fd, s1_fd;
   logic [DW-1:0] mem [256];

   assign g0   = b0_req;
   assign g1   = b1_req && !b0_req;
   assign gadr = g0 ? b0_adr : b1_adr;
   assign brd  = (g0 && s1_fl) ? s1_fd : (g1 && s0_fl) ? s0_fd : mem[gadr];

   wo_coh_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cv[0]), .cpu_we(cw[0]), .cpu_addr(ca[0]), .cpu_wdata(cd[0]),
      .cpu_ready(cr0), .cpu_rdata(cq0),
      .bus_req(b0_req), .bus_gnt(g0), .bus_op(b0_op), .bus_addr(b0_adr),
      .bus_wdata(b0_wd), .bus_rdata(brd),
      .snp_valid(g1), .snp_op(b1_op), .snp_addr(b1_adr),
      .snp_flush(s0_fl), .snp_fdata(s0_fd));

   wo_coh_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) peer (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cv[1]), .cpu_we(cw[1]), .cpu_addr(ca[1]), .cpu_wdata(cd[1]),
      .cpu_ready(cr1), .cpu_rdata(cq1),
      .bus_req(b1_req), .bus_gnt(g1), .bus_op(b1_op), .bus_addr(b1_adr),
      .bus_wdata(b1_wd), .bus_rdata(brd),
      .snp_valid(g0), .snp_op(b0_op), .snp_addr(b0_adr),
      .snp_flush(s1_fl), .snp_fdata(s1_fd));

   // shared memory: write-through, write-back and intervention data land here
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= DW'(i * 7 + 3);
      end else begin
         if (g0 && (b0_op == 2'd1 || b0_op == 2'd2)) mem[b0_adr] <= b0_wd;
         if (g1 && (b1_op == 2'd1 || b1_op == 2'd2)) mem[b1_adr] <= b1_wd;
         if (g0 && s1_fl) mem[b0_adr] <= s1_fd;
         if (g1 && s0_fl) mem[b1_adr] <= s0_fd;
      end
   end

   int n_chk = 0;
   int n_bad = 0;
   bitem_t exq [$];

   int            ms [2][LINES];
   logic [5:0]    mt [2][LINES];
   logic [DW-1:0] md [2][LINES];
   logic [DW-1:0] rmem [256];

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic push(input int cid, input logic [1:0] op, input logic [AW-1:0] adr,
                       input logic [DW-1:0] dat, input logic fl, input string rq);
      bitem_t it;
      it.cid = cid; it.op = op; it.adr = adr; it.dat = dat; it.fl = fl; it.rq = rq;
      exq.push_back(it);
   endtask

   // monitor: compare each granted transaction with the scoreboard front
   always begin
      @(negedge clk);
      #2;
      if (rst_n && (g0 || g1)) begin
         bitem_t it;
         int            cid;
         logic [1:0]    op;
         logic [AW-1:0] adr;
         logic [DW-1:0] dat;
         logic          fl;
         cid = g0 ? 0 : 1;
         op  = g0 ? b0_op : b1_op;
         adr = g0 ? b0_adr : b1_adr;
         dat = (op == 2'd0) ? brd : (g0 ? b0_wd : b1_wd);
         fl  = g0 ? s1_fl : s0_fl;
         n_chk++;
         if (exq.size() == 0) begin
            n_bad++;
            $display("FAIL R10 unexpected bus item: actual cache %0d op %0d addr %h data %h, expected none",
                     cid, op, adr, dat);
         end else begin
            it = exq.pop_front();
            if (it.cid != cid || it.op != op || it.adr != adr || it.dat != dat || it.fl != fl) begin
               n_bad++;
               $display("FAIL %s bus item: actual cache %0d op %0d addr %h data %h flush %0d, expected cache %0d op %0d addr %h data %h flush %0d",
                        it.rq, cid, op, adr, dat, fl, it.cid, it.op, it.adr, it.dat, it.fl);
            end
         end
      end
   end

   task automatic hs(input int c, input bit we, input logic [AW-1:0] adr,
                     input logic [DW-1:0] dat, input logic [DW-1:0] exp_rd,
                     input bit chk_rd, input int exp_lat, input string rq);
      int  cyc;
      bit  done;
      logic          rdy;
      logic [DW-1:0] rd;
      @(negedge clk);
      cv[c] = 1'b1; cw[c] = we; ca[c] = adr; cd[c] = dat;
      cyc = 0; done = 1'b0;
      while (!done) begin
         #2;
         rdy = (c == 0) ? cr0 : cr1;
         rd  = (c == 0) ? cq0 : cq1;
         if (rdy) begin
            done = 1'b1;
            if (chk_rd) chk(rd == exp_rd, rq, "read data", 32'(rd), 32'(exp_rd));
            if (exp_lat >= 0) chk(cyc == exp_lat, rq, "cycles to ready", 32'(cyc), 32'(exp_lat));
         end else if (cyc > 40) begin
            done = 1'b1;
            chk(1'b0, rq, "ready never came", 32'(cyc), 32'(exp_lat));
         end
         cyc++;
         @(negedge clk);
      end
      cv[c] = 1'b0;
   endtask

   // reference model of both caches; predicts bus items, data and latency
   task automatic cpu_op(input int c, input bit we, input logic [AW-1:0] adr,
                         input logic [DW-1:0] dat, input string rq);
      int o = 1 - c;
      int ix = int'(adr[1:0]);
      logic [5:0] tg = adr[7:2];
      bit hit;
      int nb = 0;
      logic fl;
      logic [AW-1:0] va;
      logic [DW-1:0] erd;
      hit = (ms[c][ix] != 0) && (mt[c][ix] == tg);
      if (!hit && ms[c][ix] == 3) begin
         va = {mt[c][ix], 2'(ix)};
         push(c, 2'd2, va, md[c][ix], 1'b0, rq);
         rmem[va] = md[c][ix];
         ms[c][ix] = 0;
         nb++;
      end
      if (!hit) begin
         fl = 1'b0;
         if (ms[o][ix] != 0 && mt[o][ix] == tg) begin
            if (ms[o][ix] == 3) begin
               fl = 1'b1;
               rmem[adr] = md[o][ix];
            end
            if (ms[o][ix] >= 2) ms[o][ix] = 1;
         end
         push(c, 2'd0, adr, rmem[adr], fl, rq);
         ms[c][ix] = 1; mt[c][ix] = tg; md[c][ix] = rmem[adr];
         nb++;
      end
      erd = md[c][ix];
      if (we) begin
         if (ms[c][ix] == 1) begin
            push(c, 2'd1, adr, dat, 1'b0, rq);
            rmem[adr] = dat;
            if (ms[o][ix] != 0 && mt[o][ix] == tg) ms[o][ix] = 0;
            ms[c][ix] = 2;
            nb++;
         end else begin
            ms[c][ix] = 3;
         end
         md[c][ix] = dat;
      end
      hs(c, we, adr, dat, erd, !we, (nb == 0) ? 0 : 2 * nb - 1, rq);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) rmem[i] = DW'(i * 7 + 3);
      for (int c = 0; c < 2; c++) begin
         cv[c] = 1'b0; cw[c] = 1'b0; ca[c] = '0; cd[c] = '0;
         for (int j = 0; j < LINES; j++) begin
            ms[c][j] = 0; mt[c][j] = '0; md[c][j] = '0;
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      // R1: idle outputs after reset
      chk(!cr0 && !cr1, "R1", "ready idle", 32'({cr0, cr1}), 32'd0);
      chk(!b0_req && !b1_req, "R1", "bus idle", 32'({b0_req, b1_req}), 32'd0);
      chk(!s0_fl && !s1_fl, "R1", "flush idle", 32'({s0_fl, s1_fl}), 32'd0);

      cpu_op(0, 1'b0, 8'h10, '0, "R1");        // cold miss
      cpu_op(0, 1'b0, 8'h10, '0, "R2");        // hit, no bus
      cpu_op(1, 1'b0, 8'h10, '0, "R2");        // shared in both
      cpu_op(0, 1'b1, 8'h10, 16'hA1A1, "R3");  // write-through, peer invalidated
      cpu_op(0, 1'b1, 8'h10, 16'hB2B2, "R4");  // local, now Dirty
      cpu_op(1, 1'b0, 8'h10, '0, "R7");        // peer read misses, flush
      cpu_op(1, 1'b1, 8'h10, 16'hC3C3, "R6");  // invalidates cache 0
      cpu_op(0, 1'b0, 8'h10, '0, "R11");       // peer Reserved -> Valid, no flush
      cpu_op(1, 1'b1, 8'h10, 16'hD4D4, "R7");  // Valid again, so write-through
      cpu_op(0, 1'b1, 8'h25, 16'h1111, "R5");  // write miss: read + write-through
      cpu_op(0, 1'b0, 8'h35, '0, "R5");        // Reserved victim: no write-back
      cpu_op(0, 1'b1, 8'h35, 16'h2222, "R3");
      cpu_op(0, 1'b1, 8'h35, 16'h3333, "R4");
      cpu_op(0, 1'b0, 8'h45, '0, "R8");        // Dirty victim written back first
      cpu_op(1, 1'b0, 8'h35, '0, "R8");        // sees written-back data

      // R9: both write one shared line at once
      cpu_op(0, 1'b0, 8'h0A, '0, "R9");
      cpu_op(1, 1'b0, 8'h0A, '0, "R9");
      push(0, 2'd1, 8'h0A, 16'h5E5E, 1'b0, "R9");
      push(1, 2'd0, 8'h0A, 16'h5E5E, 1'b0, "R9");
      push(1, 2'd1, 8'h0A, 16'h6F6F, 1'b0, "R9");
      ms[0][2] = 0;
      ms[1][2] = 2; md[1][2] = 16'h6F6F;
      rmem[8'h0A] = 16'h6F6F;
      fork
         hs(0, 1'b1, 8'h0A, 16'h5E5E, '0, 1'b0, 1, "R9");
         hs(1, 1'b1, 8'h0A, 16'h6F6F, '0, 1'b0, 5, "R9");
      join
      cpu_op(0, 1'b0, 8'h0A, '0, "R11");       // must fetch the newest value

      repeat (4) @(negedge clk);
      // R10: every expected transaction appeared
      chk(exq.size() == 0, "R10", "items left", 32'(exq.size()), 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule